// File: doc/BRIEF.md
# Multiplied-Resolution Vertical Pulse Generator

This block drives eight vertical transfer clocks for an image sensor. All eight run from one shared position counter. Each output has its own resting level and up to three toggle points. A toggle point is stored in coarse units: the effective pixel position is the toggle value times a shared pattern length, so the pattern length sets the finest step for placing an edge. This lets wide vertical pulses be described with short register fields.

An external vertical sequence controller decides where the group starts and pulses `grpStart`. The block then counts pixel clocks from zero. When `sweepEn` is low, each line sync restarts the pattern, so the pattern repeats on every line. When `sweepEn` is high, line sync is ignored and pulses may run across line boundaries. A frame sync stops the group.

Configuration enters through a simple write port into shadow registers. It only reaches the working copy at a frame sync, so a frame is never generated with a half-updated configuration.

Top module: `vclk_pattern_gen`

## Requirements
- R1: After reset, all outputs are 0, the group is idle, and every working and shadow setting is zero.
- R2: Writes land in shadow registers and do not change the outputs. At a `vdSync` edge the shadow values become the working values. While idle, the outputs show the new start polarity one clock after that edge. Address map: address 0x00 sets the pattern length from data bits 3:0. Address 0x01 sets the start polarity, one data bit per output (bit i for output i). An address with bit 5 set writes a 12-bit toggle value: address bits 4:2 select the output and bits 1:0 select toggle 1, 2 or 3; a 0 in bits 1:0 is ignored.
- R3: At a clock edge with `grpStart` high and `vdSync` low, the outputs take their start polarity, the position counter is cleared, and the group runs from then on.
- R4: A running output inverts one clock after the position counter reaches toggle value × pattern length. Seen from the port, that is toggle value × pattern length + 1 edges after the start edge.
- R5: Each output's three toggle positions act independently of each other and of the other outputs.
- R6: A toggle value of 0 never toggles. A pattern length of 0 disables every toggle.
- R7: With `sweepEn` low, an `hdSync` edge during a run restarts the pattern: the outputs go back to their start polarity and counting starts again from position 0.
- R8: With `sweepEn` high, `hdSync` has no effect, so the pattern continues across the line boundary.
- R9: A `vdSync` edge stops the group. It has priority over `grpStart` and `hdSync`. The outputs then hold the working start polarity.
- R10: Toggles that fall on the same position each invert the output, so an even number of them leaves the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hdSync | input | 1 | Line sync pulse |
| vdSync | input | 1 | Frame sync pulse; loads the configuration and stops the group |
| grpStart | input | 1 | Group start strobe from the vertical sequence controller |
| sweepEn | input | 1 | Sweep-region enable; when high, line sync is ignored |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 6 | Register write address |
| wrData | input | 12 | Register write data |
| vOut | output | 8 | Vertical transfer clock outputs |

## Verification
A restart from `grpStart` or line sync shows at the outputs right after the edge that sees it. A toggle shows P+1 edges after the restart edge, where P is the toggle value times the length. A new polarity after a frame sync is visible one edge after that sync. The bench drives inputs on the falling edge. Before each rising edge it computes the expected vector from the working configuration and the number of edges since the last restart. It compares that vector after the next falling edge, so every result is checked in exactly the cycle it is due.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  typedef struct packed {
    logic running;
    logic restart;
  } vpgStrobe_t;
endpackage

// File: rtl/vpg_ctrl.sv
module vpg_ctrl #(
  parameter int NUM_OUT = 8,
  parameter int TOG_W   = 12,
  parameter int LEN_W   = 4,
  parameter int ADDR_W  = 6
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                hdSync,
  input  logic                                vdSync,
  input  logic                                grpStart,
  input  logic                                sweepEn,
  input  logic                                wrEn,
  input  logic [ADDR_W-1:0]                   wrAddr,
  input  logic [TOG_W-1:0]                    wrData,
  output vpg_pkg::vpgStrobe_t                 strobe,
  output logic [NUM_OUT-1:0]                  actPol,
  output logic [LEN_W-1:0]                    actLen,
  output logic [NUM_OUT-1:0][2:0][TOG_W-1:0]  actTog
);
  localparam int CH_W = $clog2(NUM_OUT);

  logic [NUM_OUT-1:0]                 shPol;
  logic [LEN_W-1:0]                   shLen;
  logic [NUM_OUT-1:0][2:0][TOG_W-1:0] shTog;
  logic                               running;
  logic [CH_W-1:0]                    wrCh;
  logic [1:0]                         wrSel;

  assign wrCh  = wrAddr[CH_W+1:2];
  assign wrSel = wrAddr[1:0];

  // frame sync wins; line sync restarts only a running group outside sweep
  assign strobe.restart = !vdSync && (grpStart || (running && hdSync && !sweepEn));
  assign strobe.running = running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shPol   <= '0;
      shLen   <= '0;
      shTog   <= '0;
      actPol  <= '0;
      actLen  <= '0;
      actTog  <= '0;
      running <= 1'b0;
    end else begin
      if (wrEn) begin
        if (wrAddr[ADDR_W-1]) begin
          if (wrSel != 2'd0) shTog[wrCh][wrSel - 2'd1] <= wrData;
        end else if (wrAddr == ADDR_W'(0)) begin
          shLen <= wrData[LEN_W-1:0];
        end else if (wrAddr == ADDR_W'(1)) begin
          shPol <= wrData[NUM_OUT-1:0];
        end
      end
      if (vdSync) begin
        actPol <= shPol;
        actLen <= shLen;
        actTog <= shTog;
      end
      if (vdSync)        running <= 1'b0;
      else if (grpStart) running <= 1'b1;
    end
  end

  // R9
  vd_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    vdSync |=> !strobe.running);
  // R3
  start_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grpStart && !vdSync) |=> strobe.running);
  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vdSync |=> ($stable(actLen) && $stable(actPol) && $stable(actTog)));
endmodule

// File: rtl/vpg_datapath.sv
module vpg_datapath #(
  parameter int NUM_OUT = 8,
  parameter int TOG_W   = 12,
  parameter int LEN_W   = 4,
  parameter int POS_W   = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  vpg_pkg::vpgStrobe_t                 strobe,
  input  logic [NUM_OUT-1:0]                  actPol,
  input  logic [LEN_W-1:0]                    actLen,
  input  logic [NUM_OUT-1:0][2:0][TOG_W-1:0]  actTog,
  output logic [NUM_OUT-1:0]                  vOut
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [POS_W-1:0]   posCnt;
  logic [NUM_OUT-1:0] hit;

  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : g_chan
    logic [2:0] match;
    for (genvar k = 0; k < 3; k++) begin : g_tog
      logic [POS_W-1:0] target;
      assign target   = POS_W'(actTog[ch][k]) * POS_W'(actLen);
      assign match[k] = (actTog[ch][k] != '0) && (actLen != '0) && (posCnt == target);
    end
    assign hit[ch] = ^match;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt <= '0;
      vOut   <= '0;
    end else if (strobe.restart) begin
      posCnt <= '0;
      vOut   <= actPol;
    end else if (strobe.running) begin
      if (posCnt != POS_MAX) posCnt <= posCnt + 1'b1;
      vOut <= vOut ^ hit;
    end else begin
      posCnt <= '0;
      vOut   <= actPol;
    end
  end

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (posCnt == '0));
  // R7
  restart_pol_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (vOut == $past(actPol)));
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.running && !strobe.restart && posCnt != POS_MAX) |=> (posCnt == $past(posCnt) + 1'b1));
endmodule

// File: rtl/vclk_pattern_gen.sv
module vclk_pattern_gen #(
  parameter int NUM_OUT = 8,
  parameter int TOG_W   = 12,
  parameter int LEN_W   = 4,
  parameter int POS_W   = 16,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hdSync,
  input  logic               vdSync,
  input  logic               grpStart,
  input  logic               sweepEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [TOG_W-1:0]   wrData,
  output logic [NUM_OUT-1:0] vOut
);
  vpg_pkg::vpgStrobe_t                strobe;
  logic [NUM_OUT-1:0]                 actPol;
  logic [LEN_W-1:0]                   actLen;
  logic [NUM_OUT-1:0][2:0][TOG_W-1:0] actTog;

  vpg_ctrl #(.NUM_OUT(NUM_OUT), .TOG_W(TOG_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hdSync(hdSync), .vdSync(vdSync), .grpStart(grpStart),
    .sweepEn(sweepEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .actPol(actPol), .actLen(actLen), .actTog(actTog)
  );

  vpg_datapath #(.NUM_OUT(NUM_OUT), .TOG_W(TOG_W), .LEN_W(LEN_W), .POS_W(POS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .actPol(actPol), .actLen(actLen),
    .actTog(actTog), .vOut(vOut)
  );
endmodule

// File: tb/sim_vclk_pattern_gen.sv
module sim_vclk_pattern_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hdSync = 1'b0, vdSync = 1'b0, grpStart = 1'b0, sweepEn = 1'b0, wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [11:0] wrData = '0;
  logic [7:0] vOut;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  // bench view of the configuration, kept from the requirement text
  logic [7:0]  shPol = '0, mPol = '0;
  logic [3:0]  shLen = '0, mLen = '0;
  logic [11:0] shTog [8][3];
  logic [11:0] mTog  [8][3];
  bit          mRun = 0;
  int          mN = 0;

  always #2 clk = ~clk;

  vclk_pattern_gen u0 (
    .clk(clk), .rstN(rstN), .hdSync(hdSync), .vdSync(vdSync), .grpStart(grpStart),
    .sweepEn(sweepEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .vOut(vOut)
  );

  function automatic logic [7:0] expVec(int n);
    logic [7:0] v = mPol;
    for (int ch = 0; ch < 8; ch++) begin
      for (int k = 0; k < 3; k++) begin
        int p = int'(mTog[ch][k]) * int'(mLen);
        if (mTog[ch][k] != 0 && mLen != 0 && p <= n - 1) v[ch] = ~v[ch];
      end
    end
    return v;
  endfunction

  task automatic check(logic [7:0] exp);
    checks++;
    if (vOut !== exp) begin
      fails++;
      $display("FAIL %s: vOut=%h expected=%h", curReq, vOut, exp);
    end
  endtask

  // one clock with the given sync inputs; expected value computed before the edge
  task automatic tick(bit st = 0, bit hd = 0, bit vd = 0);
    logic [7:0] exp;
    bit rs;
    grpStart = st; hdSync = hd; vdSync = vd;
    rs = !vd && (st || (mRun && hd && !sweepEn));
    if (rs) begin mN = 0; exp = mPol; end
    else if (mRun) begin mN++; exp = expVec(mN); end
    else begin mN = 0; exp = mPol; end
    if (vd) mRun = 0; else if (st) mRun = 1;
    if (vd) begin
      mPol = shPol; mLen = shLen;
      for (int c = 0; c < 8; c++) for (int k = 0; k < 3; k++) mTog[c][k] = shTog[c][k];
    end
    @(posedge clk); @(negedge clk);
    grpStart = 0; hdSync = 0; vdSync = 0;
    check(exp);
  endtask

  task automatic wr(logic [5:0] a, logic [11:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    if (a[5]) begin
      if (a[1:0] != 0) shTog[a[4:2]][a[1:0]-1] = d;
    end else if (a == 6'h00) shLen = d[3:0];
    else if (a == 6'h01) shPol = d[7:0];
    tick();
    wrEn = 0;
  endtask

  function automatic logic [5:0] togAddr(int ch, int k);
    return {1'b1, 3'(ch), 2'(k)};
  endfunction

  task automatic clearTogs();
    for (int c = 0; c < 8; c++) for (int k = 1; k <= 3; k++) wr(togAddr(c, k), 12'd0);
  endtask

  task automatic run(int n, bit st = 0);
    if (st) tick(1);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 8; c++) for (int k = 0; k < 3; k++) begin shTog[c][k] = 0; mTog[c][k] = 0; end
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(8'h00);
    rstN = 1;
    run(3);

    curReq = "R2";
    wr(6'h00, 12'd4);
    wr(6'h01, 12'h0A5);
    wr(togAddr(0, 1), 12'd2);
    wr(togAddr(0, 2), 12'd9);
    wr(togAddr(1, 0), 12'd7);       // R2: toggle field 0 ignored
    run(3);                           // still old polarity 0
    tick(0, 0, 1);
    run(2);

    curReq = "R4";
    run(45, 1);                       // toggles at 8 and 36

    curReq = "R5";
    wr(togAddr(1, 1), 12'd1); wr(togAddr(1, 2), 12'd3); wr(togAddr(1, 3), 12'd5);
    curReq = "R6";
    wr(togAddr(2, 1), 12'd0); wr(togAddr(2, 2), 12'd4); wr(togAddr(2, 3), 12'd0);
    curReq = "R10";
    wr(togAddr(3, 1), 12'd3); wr(togAddr(3, 2), 12'd3); wr(togAddr(3, 3), 12'd6);
    tick(0, 0, 1);
    curReq = "R5";
    run(30, 1);

    curReq = "R7";
    sweepEn = 0;
    tick(0, 1);
    run(20);
    tick(0, 1);
    run(40);

    curReq = "R8";
    sweepEn = 1;
    run(5, 1);
    tick(0, 1);
    run(40);
    sweepEn = 0;

    curReq = "R9";
    tick(1, 0, 1);                    // frame sync beats start
    run(5);
    tick(1);
    run(10);
    tick(0, 1, 1);
    run(5);

    curReq = "R6";
    wr(6'h00, 12'd0);
    tick(0, 0, 1);
    run(40, 1);
    tick(0, 0, 1);

    curReq = "R3";
    for (int it = 0; it < 40; it++) begin
      wr(6'h00, 12'($urandom_range(0, 15)));
      wr(6'h01, 12'($urandom_range(0, 255)));
      for (int c = 0; c < 8; c++) for (int k = 1; k <= 3; k++)
        wr(togAddr(c, k), 12'($urandom_range(0, 20)));
      tick(0, 0, 1);
      sweepEn = 1'($urandom_range(0, 1));
      curReq = "R4";
      tick(1);
      for (int i = 0; i < 150; i++) tick(0, ($urandom_range(0, 60) == 0));
      tick(0, 0, 1);
      sweepEn = 0;
      curReq = "R3";
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule